// File: doc/BRIEF.md
# Calendar Clock with Posted Register Writes

This block keeps wall-clock time and calendar date in two packed 32-bit registers and advances them by one second on each pulse of a one-second tick input. The time register holds seconds, minutes and hours. The date register holds day of month, month, a 6-bit year offset counted from 1970 (years 1970 to 2033) and a leap flag. Software can read and write the leap flag.

Software writes to the time or date register do not change the visible count at once. The written value is held as a pending copy, and a busy bit in the control register is set. On the next tick the pending copy is loaded and the busy bit clears. That tick is used up by the load, so the count does not also advance on it. Software is expected to poll until the busy bits are clear before it writes again.

The counter handles second, minute and hour rollover. Day rollover follows the length of the month, and February has 29 days when the leap flag is set. When the year steps, the leap flag is recomputed from the new year.

Top module: `cal_clock_regs`

## Requirements
- R1: After reset the time register reads 0x00000000, the date register reads 0x00000101 (day 1, month 1, year offset 0, leap 0), and the control register reads 0.
- R2: The register map decodes bus_addr_i. The control register is at 0x00, with the date busy bit at 7, the time busy bit at 8, and every other bit reading 0. The date register is at 0x10, with day in [4:0], month in [11:8], year offset in [21:16] and leap at bit 22. The time register is at 0x14, with seconds in [5:0], minutes in [13:8] and hours in [20:16]. All bits outside these fields read 0, and a write to any other offset, including 0x00, changes nothing that can be read.
- R3: A write to the time register sets busy bit 8 on the next cycle, and a write to the date register sets busy bit 7 on the next cycle. Until the commit, the register keeps reading its old value.
- R4: While no tick arrives, the time and date registers hold their values and the busy bits stay set.
- R5: On the first tick after a write, the pending value is loaded into its register and the busy bit clears on the same clock edge.
- R6: A tick that arrives while either busy bit is set is used up by the commit. A register with no pending write does not advance on that tick.
- R7: Each tick with no commit pending adds one second. When the current field is at or above its limit, seconds wrap at 59, minutes at 59 and hours at 23, each carrying into the next field.
- R8: When the hour wraps, the day wraps to 1 once it is at or above the month length: 30 days for months 4, 6, 9 and 11, 29 days for month 2 when leap is 1 and 28 when leap is 0, and 31 days otherwise. When the day wraps, the month wraps from 12 (or above) to 1.
- R9: When the month wraps, the year offset increments modulo 64. The leap flag then becomes 1 exactly when (1970 + year) mod 4 equals 0, so offset 63 wraps to 0 with leap 0.
- R10: A write that arrives in the same cycle as a commit tick does not take part in that commit. It becomes the new pending value, with its busy bit set. When several writes arrive before a tick, the last one wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| tick_i | input | 1 | One-cycle pulse, once per second |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |

## Verification
Field-limit patterns are chosen so that each carry boundary is reached directly: 23:59:58 and 23:59:59 on the last day of February (leap 0 and leap 1), of April and of December. These tell apart errors in month length, in leap handling and in year wrap. Writes are given in three timings: isolated, back to back before a tick, and in the same cycle as a commit tick. These separate "tick used up by the commit" from "tick also advances" and "late write lost". Out-of-range field values and writes to unmapped or read-only offsets show whether the limit comparisons are robust and whether the address decode is exact. A behavioural model tracks every cycle alongside these directed checks.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DAY_W  = 5;
  localparam int MON_W  = 4;
  localparam int YEAR_W = 6;
  localparam int BASE_YEAR = 1970;
  localparam int REG_W = 32;
  localparam int HMS_W = HOUR_W + MIN_W + SEC_W;
  localparam int YMD_W = 1 + YEAR_W + MON_W + DAY_W;

  localparam int OFS_CTRL = 'h00;
  localparam int OFS_DATE = 'h10;
  localparam int OFS_TIME = 'h14;
  localparam int BUSY_DATE_BIT = 7;
  localparam int BUSY_TIME_BIT = 8;

  typedef struct packed {
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } hms_t;

  typedef struct packed {
    logic              leap;
    logic [YEAR_W-1:0] year;
    logic [MON_W-1:0]  mon;
    logic [DAY_W-1:0]  day;
  } ymd_t;

  function automatic hms_t hms_unpack(input logic [REG_W-1:0] w);
    hms_t t;
    t.sec  = w[5:0];
    t.min  = w[13:8];
    t.hour = w[20:16];
    return t;
  endfunction

  function automatic logic [REG_W-1:0] hms_pack(input hms_t t);
    logic [REG_W-1:0] w;
    w        = '0;
    w[5:0]   = t.sec;
    w[13:8]  = t.min;
    w[20:16] = t.hour;
    return w;
  endfunction

  function automatic ymd_t ymd_unpack(input logic [REG_W-1:0] w);
    ymd_t d;
    d.day  = w[4:0];
    d.mon  = w[11:8];
    d.year = w[21:16];
    d.leap = w[22];
    return d;
  endfunction

  function automatic logic [REG_W-1:0] ymd_pack(input ymd_t d);
    logic [REG_W-1:0] w;
    w        = '0;
    w[4:0]   = d.day;
    w[11:8]  = d.mon;
    w[21:16] = d.year;
    w[22]    = d.leap;
    return w;
  endfunction

  function automatic logic [DAY_W-1:0] month_last_day(input logic [MON_W-1:0] m,
                                                      input logic leap);
    case (m)
      MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11): return DAY_W'(30);
      MON_W'(2): return leap ? DAY_W'(29) : DAY_W'(28);
      default:   return DAY_W'(31);
    endcase
  endfunction
endpackage

// File: rtl/cal_rst_sync.sv
module cal_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cal_post_stage.sv
module cal_post_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         tick,
  output logic         busy_o,
  output logic [W-1:0] pend_o
);
  logic         busy_q, busy_d;
  logic [W-1:0] pend_q, pend_d;

  always_comb begin
    busy_d = busy_q;
    if (tick)  busy_d = 1'b0;
    if (wr_en) busy_d = 1'b1;
    pend_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= '0;
    end else begin
      busy_q <= busy_d;
      if (wr_en) pend_q <= pend_d;
    end
  end

  assign busy_o = busy_q;
  assign pend_o = pend_q;

  // R3: a write raises busy on the following cycle
  a_r3_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> busy_q);
  // R5: a tick with no new write drops busy
  a_r5_busy_clears: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && tick && !wr_en |=> !busy_q);
  // R10: the last write is the one held
  a_r10_last_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pend_q == $past(wr_data));
endmodule

// File: rtl/cal_advance.sv
module cal_advance
  import cal_pkg::*;
(
  input  hms_t t_cur,
  input  ymd_t d_cur,
  output hms_t t_nxt,
  output ymd_t d_nxt
);
  logic              sec_wrap, min_wrap, hour_wrap, day_wrap, mon_wrap;
  logic              day_step, mon_step, year_step;
  logic [YEAR_W-1:0] year_inc;
  logic [10:0]       year_abs;

  always_comb begin
    sec_wrap  = t_cur.sec  >= SEC_W'(59);
    min_wrap  = t_cur.min  >= MIN_W'(59);
    hour_wrap = t_cur.hour >= HOUR_W'(23);
    day_wrap  = d_cur.day  >= month_last_day(d_cur.mon, d_cur.leap);
    mon_wrap  = d_cur.mon  >= MON_W'(12);
    day_step  = sec_wrap & min_wrap & hour_wrap;
    mon_step  = day_step & day_wrap;
    year_step = mon_step & mon_wrap;
    year_inc  = d_cur.year + 1'b1;
    year_abs  = 11'(BASE_YEAR) + {{(11-YEAR_W){1'b0}}, year_inc};

    t_nxt = t_cur;
    d_nxt = d_cur;
    t_nxt.sec = sec_wrap ? '0 : t_cur.sec + 1'b1;
    if (sec_wrap)
      t_nxt.min = min_wrap ? '0 : t_cur.min + 1'b1;
    if (sec_wrap && min_wrap)
      t_nxt.hour = hour_wrap ? '0 : t_cur.hour + 1'b1;
    if (day_step)
      d_nxt.day = day_wrap ? DAY_W'(1) : d_cur.day + 1'b1;
    if (mon_step)
      d_nxt.mon = mon_wrap ? MON_W'(1) : d_cur.mon + 1'b1;
    if (year_step) begin
      d_nxt.year = year_inc;
      d_nxt.leap = (year_abs[1:0] == 2'b00);
    end
  end
endmodule

// File: rtl/cal_clock_regs.sv
module cal_clock_regs
  import cal_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(OFS_DATE);
  localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(OFS_TIME);

  logic             rst_q_n;
  logic             wr_time, wr_date;
  logic             t_busy, d_busy, any_busy, commit;
  logic [HMS_W-1:0] t_pend;
  logic [YMD_W-1:0] d_pend;
  hms_t             hms_q, hms_d, hms_adv;
  ymd_t             ymd_q, ymd_d, ymd_adv;

  cal_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  assign wr_time = bus_wr_i && (bus_addr_i == A_TIME);
  assign wr_date = bus_wr_i && (bus_addr_i == A_DATE);

  cal_post_stage #(.W(HMS_W)) u_time_stage (
    .clk(clk), .rst_n(rst_q_n), .wr_en(wr_time),
    .wr_data(hms_unpack(bus_wdata_i)), .tick(tick_i),
    .busy_o(t_busy), .pend_o(t_pend)
  );

  cal_post_stage #(.W(YMD_W)) u_date_stage (
    .clk(clk), .rst_n(rst_q_n), .wr_en(wr_date),
    .wr_data(ymd_unpack(bus_wdata_i)), .tick(tick_i),
    .busy_o(d_busy), .pend_o(d_pend)
  );

  cal_advance u_adv (
    .t_cur(hms_q), .d_cur(ymd_q), .t_nxt(hms_adv), .d_nxt(ymd_adv)
  );

  assign any_busy = t_busy | d_busy;
  assign commit   = tick_i & any_busy;

  always_comb begin
    hms_d = hms_q;
    ymd_d = ymd_q;
    if (commit) begin
      if (t_busy) hms_d = hms_t'(t_pend);
      if (d_busy) ymd_d = ymd_t'(d_pend);
    end else if (tick_i) begin
      hms_d = hms_adv;
      ymd_d = ymd_adv;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      hms_q <= '0;
      ymd_q <= '{leap: 1'b0, year: '0, mon: MON_W'(1), day: DAY_W'(1)};
    end else if (tick_i) begin
      hms_q <= hms_d;
      ymd_q <= ymd_d;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_CTRL: begin
        bus_rdata_o[BUSY_TIME_BIT] = t_busy;
        bus_rdata_o[BUSY_DATE_BIT] = d_busy;
      end
      A_DATE:  bus_rdata_o = ymd_pack(ymd_q);
      A_TIME:  bus_rdata_o = hms_pack(hms_q);
      default: bus_rdata_o = '0;
    endcase
  end

  // R4: with no tick the counters do not move
  a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_q_n)
    !tick_i |=> $stable(hms_q) && $stable(ymd_q));
  // R5: a commit loads the posted time value
  a_r5_commit_loads: assert property (@(posedge clk) disable iff (!rst_q_n)
    tick_i && t_busy |=> hms_q == hms_t'($past(t_pend)));
  // R6: a date-only commit leaves the time untouched
  a_r6_tick_consumed: assert property (@(posedge clk) disable iff (!rst_q_n)
    tick_i && d_busy && !t_busy |=> $stable(hms_q));
  // R7: seconds at or above 59 wrap to zero on a free tick
  a_r7_sec_wrap: assert property (@(posedge clk) disable iff (!rst_q_n)
    tick_i && !any_busy && hms_q.sec >= SEC_W'(59) |=> hms_q.sec == '0);
  // R9: a year step leaves the leap flag consistent with the new year
  a_r9_leap_on_year_step: assert property (@(posedge clk) disable iff (!rst_q_n)
    tick_i && !any_busy |=>
      (ymd_q.year == $past(ymd_q.year)) || (ymd_q.leap == (ymd_q.year[1:0] == 2'd2)));
endmodule

// File: tb/sim_cal_clock_regs.sv
`timescale 1ns/1ps
module sim_cal_clock_regs;
  logic        clk;
  logic        rst_n;
  logic        tick_i;
  logic        bus_wr_i;
  logic [7:0]  bus_addr_i;
  logic [31:0] bus_wdata_i;
  logic [31:0] bus_rdata_o;

  integer errors = 0;
  integer checks = 0;
  integer live = 0;

  cal_clock_regs #(.ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_wr_i(bus_wr_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // behavioural reference model
  integer m_s, m_mi, m_h, m_d, m_mo, m_y, m_lp;
  integer p_s, p_mi, p_h, p_d, p_mo, p_y, p_lp;
  integer m_tb, m_db;

  function automatic integer days_in(input integer mo, input integer lp);
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    if (mo == 2) return (lp != 0) ? 29 : 28;
    return 31;
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    logic [31:0] w;
    w = 0;
    if (a == 8'h00) begin w[8] = (m_tb != 0); w[7] = (m_db != 0); end
    else if (a == 8'h10) w = m_d + m_mo * 256 + m_y * 65536 + m_lp * 4194304;
    else if (a == 8'h14) w = m_s + m_mi * 256 + m_h * 65536;
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s = 0; m_mi = 0; m_h = 0; m_d = 1; m_mo = 1; m_y = 0; m_lp = 0;
      m_tb = 0; m_db = 0;
    end else begin
      if (tick_i) begin
        if (m_tb != 0 || m_db != 0) begin
          if (m_tb != 0) begin m_s = p_s; m_mi = p_mi; m_h = p_h; end
          if (m_db != 0) begin m_d = p_d; m_mo = p_mo; m_y = p_y; m_lp = p_lp; end
          m_tb = 0; m_db = 0;
        end else if (m_s >= 59) begin
          m_s = 0;
          if (m_mi >= 59) begin
            m_mi = 0;
            if (m_h >= 23) begin
              m_h = 0;
              if (m_d >= days_in(m_mo, m_lp)) begin
                m_d = 1;
                if (m_mo >= 12) begin
                  m_mo = 1;
                  m_y = (m_y + 1) % 64;
                  m_lp = ((1970 + m_y) % 4 == 0) ? 1 : 0;
                end else m_mo = m_mo + 1;
              end else m_d = m_d + 1;
            end else m_h = m_h + 1;
          end else m_mi = m_mi + 1;
        end else m_s = m_s + 1;
      end
      if (bus_wr_i && bus_addr_i == 8'h14) begin
        p_s = bus_wdata_i[5:0]; p_mi = bus_wdata_i[13:8]; p_h = bus_wdata_i[20:16];
        m_tb = 1;
      end
      if (bus_wr_i && bus_addr_i == 8'h10) begin
        p_d = bus_wdata_i[4:0]; p_mo = bus_wdata_i[11:8];
        p_y = bus_wdata_i[21:16]; p_lp = bus_wdata_i[22];
        m_db = 1;
      end
    end
  end

  // per-cycle comparison against the model (R2 register view)
  always @(negedge clk) begin
    #1;
    if (live != 0) begin
      checks = checks + 1;
      if (bus_rdata_o !== model_read(bus_addr_i)) begin
        errors = errors + 1;
        $display("FAIL R2 model compare addr=%h actual=%h expected=%h",
                 bus_addr_i, bus_rdata_o, model_read(bus_addr_i));
      end
    end
  end

  task automatic cyc(input logic wr, input logic [7:0] a, input logic [31:0] dat,
                     input logic tk);
    @(negedge clk);
    bus_wr_i = wr; bus_addr_i = a; bus_wdata_i = dat; tick_i = tk;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    cyc(1'b0, a, 32'h0, 1'b0);
    #1;
    checks = checks + 1;
    if (bus_rdata_o !== exp) begin
      errors = errors + 1;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata_o, exp);
    end
  endtask

  task automatic tk();
    cyc(1'b0, 8'h00, 32'h0, 1'b1);
  endtask

  task automatic put(input logic [7:0] a, input logic [31:0] dat);
    cyc(1'b1, a, dat, 1'b0);
  endtask

  task automatic set_and_commit(input logic [31:0] t, input logic [31:0] d);
    put(8'h14, t);
    put(8'h10, d);
    tk();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_i = 1'b0; bus_wr_i = 1'b0; bus_addr_i = 8'h00; bus_wdata_i = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    live = 1;

    // R1 reset state
    rd(8'h00, 32'h0, "R1 ctrl");
    rd(8'h10, 32'h00000101, "R1 date");
    rd(8'h14, 32'h0, "R1 time");

    // R7 plain counting
    tk(); rd(8'h14, 32'h1, "R7 count");
    tk(); tk(); rd(8'h14, 32'h3, "R7 count");

    // R3 posted write, R4 hold
    put(8'h14, 32'h00173B3A);
    rd(8'h00, 32'h100, "R3 time busy");
    rd(8'h14, 32'h3, "R3 old time visible");
    repeat (5) cyc(1'b0, 8'h10, 32'h0, 1'b0);
    rd(8'h00, 32'h100, "R4 busy held");
    rd(8'h14, 32'h3, "R4 time held");
    put(8'h10, 32'h0001021C);
    rd(8'h00, 32'h180, "R3 both busy");
    tk();
    rd(8'h00, 32'h0, "R5 busy cleared");
    rd(8'h14, 32'h00173B3A, "R6 committed not advanced");
    rd(8'h10, 32'h0001021C, "R5 date committed");
    tk(); rd(8'h14, 32'h00173B3B, "R7 sec step");
    tk();
    rd(8'h14, 32'h0, "R7 day wrap time");
    rd(8'h10, 32'h00010301, "R8 feb 28 days");

    // R6 date-only commit leaves time alone
    put(8'h10, 32'h00010305); tk();
    rd(8'h14, 32'h0, "R6 time not advanced");

    // R8 leap February, April, and R9 year steps
    set_and_commit(32'h00173B3B, 32'h0042021C); tk();
    rd(8'h10, 32'h0042021D, "R8 feb 29 leap");
    put(8'h14, 32'h00173B3B); tk(); tk();
    rd(8'h10, 32'h00420301, "R8 leap feb end");
    set_and_commit(32'h00173B3B, 32'h0042041E); tk();
    rd(8'h10, 32'h00420501, "R8 april 30 days");
    set_and_commit(32'h00173B3B, 32'h00420C1F); tk();
    rd(8'h10, 32'h00030101, "R9 leap cleared");
    set_and_commit(32'h00173B3B, 32'h00010C1F); tk();
    rd(8'h10, 32'h00420101, "R9 leap set");
    set_and_commit(32'h00173B3B, 32'h003F0C1F); tk();
    rd(8'h10, 32'h00000101, "R9 year wrap");

    // R10 write during commit tick and last-write-wins
    put(8'h14, 32'h00010203);
    cyc(1'b1, 8'h14, 32'h00050607, 1'b1);
    rd(8'h14, 32'h00010203, "R10 commit uses earlier");
    rd(8'h00, 32'h100, "R10 new write pending");
    tk(); rd(8'h14, 32'h00050607, "R10 late write committed");
    put(8'h14, 32'h1); put(8'h14, 32'h2); tk();
    rd(8'h14, 32'h2, "R10 last write wins");

    // R2 decode and unused bits
    put(8'h18, 32'hFFFFFFFF);
    put(8'h00, 32'hFFFFFFFF);
    rd(8'h00, 32'h0, "R2 ctrl not writable");
    rd(8'h14, 32'h2, "R2 stray write time");
    rd(8'h10, 32'h00000101, "R2 stray write date");
    put(8'h14, 32'hFFFFFFFF); tk();
    rd(8'h14, 32'h001F3F3F, "R2 unused bits zero");
    tk();
    rd(8'h14, 32'h0, "R7 out-of-range fields wrap");
    rd(8'h10, 32'h00000102, "R8 day carry");

    repeat (3) tk();
    live = 0;
    @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule